// File: doc/BRIEF.md
# CPU Load/Store to Wishbone Byte-Lane Adapter

This block connects the data-memory port of a small processor to a 32-bit Wishbone master interface. The processor presents a byte address, a size code, a write flag, write data and a request. The adapter starts a word-aligned bus cycle. It marks the addressed byte lanes with the select mask and holds cycle and strobe until the slave acknowledges.

Byte positions appear on the bus only through the select mask. Store data is copied into every lane, and the mask picks which lanes the slave writes. A load leaves the read word exactly as the slave returns it. The adapter then picks out the addressed byte or half-word, moves it to the low bits, and extends it with the sign or with zeros. A parameter selects little-endian or big-endian lane numbering.

Top module: `lsw_adapter`

## Requirements
- R1: While reset is asserted, and right after it is released, `wb_cyc_o`, `wb_stb_o` and `cpu_rsp_valid` are low and `cpu_ready` is high.
- R2: A request seen at a clock edge while `cpu_ready` is high starts a bus cycle. From the next cycle `wb_cyc_o` and `wb_stb_o` are high and `wb_we_o` equals the write flag. Address, mask and data stay unchanged until the acknowledge. Requests made during the cycle are ignored.
- R3: `wb_adr_o` is the captured byte address with bits [1:0] forced to 00.
- R4: The size code uses bits [1:0] for the width: 0 is byte, 1 is half-word, 2 is word. Bit 2 set means unsigned. A half-word access is defined only for address low bits 00 and 10.
- R5: Little-endian, with address low bits a: a byte access gives mask 1<<a, and a half-word access gives mask 3<<a.
- R6: Big-endian, with address low bits a: a byte access gives mask 8>>a, and a half-word access gives mask 0xC>>a.
- R7: A word access always drives mask 0xF.
- R8: Store data is replicated across lanes. A byte store fills all four lanes with the byte. A half-word store fills both halves with the half-word. A word store drives the word unchanged.
- R9: A load returns the addressed byte or half-word in the low bits of `cpu_rdata`. The value is sign-extended when size bit 2 is clear and zero-extended when it is set. A word load returns the bus word unchanged.
- R10: After the edge that samples `wb_ack_i`, `wb_cyc_o` and `wb_stb_o` are low and `cpu_rsp_valid` is high for exactly one cycle.
- R11: A request made during the response cycle is accepted, so a new bus cycle starts directly after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 3 | Size code: [1:0] width, [2] unsigned |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_ready | output | 1 | Adapter idle, request will be taken |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Extracted and extended load result |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | ADDR_W | Word-aligned address |
| wb_sel_o | output | 4 | Byte-lane select mask |
| wb_dat_o | output | 32 | Lane-replicated store data |
| wb_dat_i | input | 32 | Read data from slave |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
Two events can fall in the same cycle: the response pulse for one access and the acceptance of the next request. The bench provokes this by raising a new request during the response cycle. It then checks that the response carries the old load result, and that the bus cycle, address and mask for the new access appear on the next cycle. Requests held high while a bus cycle is open are also driven. The bus address is expected to stay unchanged and no extra cycle may follow.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2,
    WID_RSVD = 2'd3
  } width_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } state_e;
endpackage

// File: rtl/lsw_mask_gen.sv
module lsw_mask_gen
  import lsw_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  width_e           wid,
  input  logic [1:0]       ofs,
  output logic [LANES-1:0] sel
);
  logic [LANES-1:0] byte_mask;
  logic [LANES-1:0] half_mask;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign byte_mask = 4'b1000 >> ofs;
      assign half_mask = 4'b1100 >> ofs;
    end else begin : g_little
      assign byte_mask = 4'b0001 << ofs;
      assign half_mask = 4'b0011 << ofs;
    end
  endgenerate

  always_comb begin
    unique case (wid)
      WID_BYTE: sel = byte_mask;
      WID_HALF: sel = half_mask;
      default:  sel = {LANES{1'b1}};
    endcase
  end
endmodule

// File: rtl/lsw_store_pack.sv
module lsw_store_pack
  import lsw_pkg::*;
(
  input  width_e            wid,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] lanes
);
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
        unique case (wid)
          WID_BYTE: lanes[BYTE_W*i +: BYTE_W] = wdata[BYTE_W-1:0];
          WID_HALF: lanes[BYTE_W*i +: BYTE_W] = wdata[BYTE_W*(i%2) +: BYTE_W];
          default:  lanes[BYTE_W*i +: BYTE_W] = wdata[BYTE_W*i +: BYTE_W];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/lsw_load_extract.sv
module lsw_load_extract
  import lsw_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  width_e            wid,
  input  logic              uns,
  input  logic [1:0]        ofs,
  input  logic [WORD_W-1:0] bus,
  output logic [WORD_W-1:0] res
);
  localparam int HALF_W = 2 * BYTE_W;

  logic [1:0]        byte_idx;
  logic              half_hi;
  logic [BYTE_W-1:0] byte_val;
  logic [HALF_W-1:0] half_val;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign byte_idx = ~ofs;
      assign half_hi  = ~ofs[1];
    end else begin : g_little
      assign byte_idx = ofs;
      assign half_hi  = ofs[1];
    end
  endgenerate

  assign byte_val = bus[BYTE_W*byte_idx +: BYTE_W];
  assign half_val = half_hi ? bus[WORD_W-1:HALF_W] : bus[HALF_W-1:0];

  always_comb begin
    unique case (wid)
      WID_BYTE: res = {{(WORD_W-BYTE_W){~uns & byte_val[BYTE_W-1]}}, byte_val};
      WID_HALF: res = {{(WORD_W-HALF_W){~uns & half_val[HALF_W-1]}}, half_val};
      default:  res = bus;
    endcase
  end
endmodule

// File: rtl/lsw_adapter.sv
module lsw_adapter
  import lsw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rsp_valid,
  output logic [31:0]       cpu_rdata,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [3:0]        wb_sel_o,
  output logic [31:0]       wb_dat_o,
  input  logic [31:0]       wb_dat_i,
  input  logic              wb_ack_i
);
  state_e             state_q, state_d;
  logic               we_q;
  width_e             wid_q;
  logic               uns_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic               rsp_q, rsp_d;
  logic [WORD_W-1:0]  rdata_q;
  logic [WORD_W-1:0]  load_val;
  logic               accept;
  logic               finish;
  logic               rdata_en;

  // next-state logic
  always_comb begin
    accept   = (state_q == ST_IDLE) && cpu_req;
    finish   = (state_q == ST_BUSY) && wb_ack_i;
    rdata_en = finish && !we_q;
    rsp_d    = finish;
    state_d  = state_q;
    if (accept)      state_d = ST_BUSY;
    else if (finish) state_d = ST_IDLE;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rsp_d;
    end
  end

  // access capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      wid_q   <= WID_WORD;
      uns_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= cpu_we;
      wid_q   <= width_e'(cpu_size[1:0]);
      uns_q   <= cpu_size[2];
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end
  end

  // load result, enabled on acknowledged load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= load_val;
    end
  end

  lsw_mask_gen #(.BIG_ENDIAN(BIG_ENDIAN)) u_mask (
    .wid (wid_q),
    .ofs (addr_q[1:0]),
    .sel (wb_sel_o)
  );

  lsw_store_pack u_pack (
    .wid   (wid_q),
    .wdata (wdata_q),
    .lanes (wb_dat_o)
  );

  lsw_load_extract #(.BIG_ENDIAN(BIG_ENDIAN)) u_extract (
    .wid (wid_q),
    .uns (uns_q),
    .ofs (addr_q[1:0]),
    .bus (wb_dat_i),
    .res (load_val)
  );

  assign wb_cyc_o      = (state_q == ST_BUSY);
  assign wb_stb_o      = (state_q == ST_BUSY);
  assign wb_we_o       = we_q;
  assign wb_adr_o      = {addr_q[ADDR_W-1:2], 2'b00};
  assign cpu_ready     = (state_q == ST_IDLE);
  assign cpu_rsp_valid = rsp_q;
  assign cpu_rdata     = rdata_q;

  // R2
  req_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready |=> wb_cyc_o && wb_stb_o);

  // R2
  cycle_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o && !wb_ack_i |=> wb_cyc_o && $stable(wb_adr_o) && $stable(wb_sel_o) && $stable(wb_dat_o));

  // R10
  ack_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o && wb_ack_i |=> cpu_rsp_valid && !wb_cyc_o);

  // R10
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // R5
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o && (wid_q == WID_BYTE) |-> $countones(wb_sel_o) == 1);

  // R7
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o && (wid_q == WID_WORD) |-> wb_sel_o == 4'hF);
endmodule

// File: tb/lsw_adapter_test.sv
`timescale 1ns/1ps
module lsw_adapter_test;
  logic        clk;
  logic        rst_n;
  logic        cpu_req;
  logic        cpu_we;
  logic [2:0]  cpu_size;
  logic [31:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic [31:0] wb_dat_i;
  logic        wb_ack_i;

  logic        le_ready, le_rsp, le_cyc, le_stb, le_we;
  logic [31:0] le_rdata, le_adr, le_dat;
  logic [3:0]  le_sel;
  logic        be_ready, be_rsp, be_cyc, be_stb, be_we;
  logic [31:0] be_rdata, be_adr, be_dat;
  logic [3:0]  be_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  lsw_adapter #(.ADDR_W(32), .BIG_ENDIAN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(le_ready), .cpu_rsp_valid(le_rsp), .cpu_rdata(le_rdata),
    .wb_cyc_o(le_cyc), .wb_stb_o(le_stb), .wb_we_o(le_we), .wb_adr_o(le_adr),
    .wb_sel_o(le_sel), .wb_dat_o(le_dat), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
  );

  lsw_adapter #(.ADDR_W(32), .BIG_ENDIAN(1'b1)) uut_be (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(be_ready), .cpu_rsp_valid(be_rsp), .cpu_rdata(be_rdata),
    .wb_cyc_o(be_cyc), .wb_stb_o(be_stb), .wb_we_o(be_we), .wb_adr_o(be_adr),
    .wb_sel_o(be_sel), .wb_dat_o(be_dat), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_sel(input bit be, input logic [2:0] sc, input logic [1:0] a);
    int lane, hh;
    lane = be ? 3 - int'(a) : int'(a);
    hh   = be ? 1 - int'(a[1]) : int'(a[1]);
    if (sc[1:0] == 2'd0) return 4'(1 << lane);
    if (sc[1:0] == 2'd1) return 4'(3 << (2 * hh));
    return 4'hF;
  endfunction

  function automatic logic [31:0] exp_store(input logic [2:0] sc, input logic [31:0] w);
    if (sc[1:0] == 2'd0) return {24'd0, w[7:0]} * 32'h0101_0101;
    if (sc[1:0] == 2'd1) return {16'd0, w[15:0]} * 32'h0001_0001;
    return w;
  endfunction

  function automatic logic [31:0] exp_load(input bit be, input logic [2:0] sc, input logic [1:0] a,
                                           input logic [31:0] bus);
    int lane, hh;
    logic [31:0] v;
    lane = be ? 3 - int'(a) : int'(a);
    hh   = be ? 1 - int'(a[1]) : int'(a[1]);
    if (sc[1:0] == 2'd0) begin
      v = (bus >> (8 * lane)) & 32'hFF;
      if (!sc[2] && v >= 32'h80) v = v | 32'hFFFF_FF00;
    end else if (sc[1:0] == 2'd1) begin
      v = (bus >> (16 * hh)) & 32'hFFFF;
      if (!sc[2] && v >= 32'h8000) v = v | 32'hFFFF_0000;
    end else begin
      v = bus;
    end
    return v;
  endfunction

  task automatic check_bus(input bit we, input logic [2:0] sc, input logic [31:0] addr,
                           input logic [31:0] wd);
    chk("R2 le cyc/stb", {le_cyc, le_stb}, 2'b11);
    chk("R2 be cyc/stb", {be_cyc, be_stb}, 2'b11);
    chk("R2 le we", le_we, we);
    chk("R2 be we", be_we, we);
    chk("R3 le adr", le_adr, addr & 32'hFFFF_FFFC);
    chk("R3 be adr", be_adr, addr & 32'hFFFF_FFFC);
    chk(sc[1:0] == 2'd2 ? "R7 le sel" : "R5 le sel", le_sel, exp_sel(1'b0, sc, addr[1:0]));
    chk(sc[1:0] == 2'd2 ? "R7 be sel" : "R6 be sel", be_sel, exp_sel(1'b1, sc, addr[1:0]));
    if (we) begin
      chk("R8 le dat", le_dat, exp_store(sc, wd));
      chk("R8 be dat", be_dat, exp_store(sc, wd));
    end
  endtask

  task automatic access(input bit we, input logic [2:0] sc, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [31:0] rbus, input int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_size = sc; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    check_bus(we, sc, addr, wd);
    cpu_req = 1'b1; cpu_we = ~we; cpu_size = 3'd2; cpu_addr = ~addr; cpu_wdata = ~wd;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R2 le adr held", le_adr, addr & 32'hFFFF_FFFC);
      chk("R2 be sel held", be_sel, exp_sel(1'b1, sc, addr[1:0]));
    end
    cpu_req = 1'b0; wb_ack_i = 1'b1; wb_dat_i = rbus;
    @(negedge clk);
    wb_ack_i = 1'b0; wb_dat_i = ~rbus;
    chk("R10 le rsp", {le_rsp, le_cyc, le_stb}, 3'b100);
    chk("R10 be rsp", {be_rsp, be_cyc, be_stb}, 3'b100);
    if (!we) begin
      chk("R9 le rdata", le_rdata, exp_load(1'b0, sc, addr[1:0], rbus));
      chk("R9 be rdata", be_rdata, exp_load(1'b1, sc, addr[1:0], rbus));
    end
    @(negedge clk);
    chk("R10 le single", {le_rsp, le_cyc}, 2'b00);
    chk("R2 be ignored", {be_rsp, be_cyc}, 2'b00);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int codes[5] = '{0, 1, 2, 4, 5};
    int n = 0;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 3'd0;
    cpu_addr = '0; cpu_wdata = '0; wb_dat_i = '0; wb_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 le reset", {le_cyc, le_stb, le_rsp, le_ready}, 4'b0001);
    chk("R1 be reset", {be_cyc, be_stb, be_rsp, be_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 le after release", {le_cyc, le_stb, le_rsp, le_ready}, 4'b0001);

    // R4 encodings swept: all defined sizes, offsets, both endiannesses
    for (int we = 0; we < 2; we++) begin
      for (int c = 0; c < 5; c++) begin
        for (int a = 0; a < 4; a++) begin
          for (int p = 0; p < 2; p++) begin
            logic [2:0] sc;
            sc = 3'(codes[c]);
            if (sc[1:0] == 2'd1 && a[0]) continue;
            if (sc[1:0] == 2'd2 && a != 0) continue;
            access(we[0], sc, 32'h4000_0100 + 32'(n << 4) + 32'(a),
                   p ? 32'h8A5C_F1E3 : 32'h3417_6B29,
                   p ? 32'hF08E_7C91 : 32'h196A_D3B4, n % 3);
            n++;
          end
        end
      end
    end

    // R11 back-to-back: new request during response cycle
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 3'd0; cpu_addr = 32'h0000_2003; cpu_wdata = '0;
    @(negedge clk);
    cpu_req = 1'b0; wb_ack_i = 1'b1; wb_dat_i = 32'h80C1_22F4;
    @(negedge clk);
    wb_ack_i = 1'b0;
    chk("R11 le rsp", le_rsp, 1'b1);
    chk("R11 le rdata", le_rdata, exp_load(1'b0, 3'd0, 2'd3, 32'h80C1_22F4));
    chk("R11 be rdata", be_rdata, exp_load(1'b1, 3'd0, 2'd3, 32'h80C1_22F4));
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 3'd1; cpu_addr = 32'h0000_3002; cpu_wdata = 32'h0000_9ABC;
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R11 le new cycle", {le_cyc, le_rsp}, 2'b10);
    chk("R11 le new adr", le_adr, 32'h0000_3000);
    chk("R11 le new sel", le_sel, exp_sel(1'b0, 3'd1, 2'd2));
    chk("R11 be new sel", be_sel, exp_sel(1'b1, 3'd1, 2'd2));
    chk("R11 be new dat", be_dat, exp_store(3'd1, 32'h0000_9ABC));
    wb_ack_i = 1'b1;
    @(negedge clk);
    wb_ack_i = 1'b0;
    chk("R11 le done", {le_rsp, le_cyc}, 2'b10);
    @(negedge clk);
    chk("R11 be idle", {be_rsp, be_cyc, be_ready}, 3'b001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule